// File: doc/BRIEF.md
# Stacked Floating-Point Register File

This block holds eight 80-bit operand registers that software and an arithmetic datapath address as a circular stack. A 3-bit top pointer selects which physical entry is logical register ST(0). ST(i) is the physical entry (top + i) mod 8, so every logical name moves whenever the stack is pushed or popped. Each entry carries an occupied tag. Pushing onto an occupied slot, or consuming an empty one, is a stack fault. A fault leaves the stack untouched and raises sticky exception flags.

One request is accepted per clock. The requests are: push an external word, push a copy of ST(i), pop, store ST(0) into ST(i) and pop, write ST(i), read ST(i), exchange ST(0) with ST(i) or with ST(1), initialise, and clear exceptions. Popped and read values come back as raw 80-bit words one cycle after the request. A 16-bit status word shows the top pointer, the stack-fault flag, its direction bit and the invalid-operation flag. Arithmetic and format conversion live elsewhere.

Top module: `fstack_regfile`

## Requirements
- R1: Logical index i (op_idx, 0..7) addresses physical entry (top + i) mod 8 for write, read, store-and-pop and exchange.
- R2: PUSH (code 1) decrements top modulo 8, then stores wr_data in the entry the new top selects and tags it occupied; if that entry is already occupied the push is an overflow.
- R3: DUP (code 2) resolves ST(i) against the top before the decrement, so DUP with index 0 duplicates the top; an empty source is an underflow, checked before overflow.
- R4: POP (code 3) returns ST(0) on rd_data, tags that entry empty and increments top modulo 8; popping an empty ST(0) is an underflow.
- R5: STPOP (code 4) copies ST(0) into ST(i) using the pre-pop index and then pops; with index 0 it is a plain pop with no transfer.
- R6: XCHG (code 7) swaps ST(0) with ST(i), XCHG1 (code 8) swaps ST(0) with ST(1); a successful exchange clears C1, and an empty ST(0) or ST(i) is an underflow.
- R7: A fault sets the stack-fault flag and the invalid-operation flag, and sets C1 to 1 for an overflow and to 0 for an underflow.
- R8: A faulting request leaves the top pointer, all entries and all tags unchanged.
- R9: The status word carries top in bits 13:11, C1 in bit 9, the summary bit in bit 7 (OR of bits 5:0), stack fault in bit 6 and invalid operation in bit 0; all other bits read 0.
- R10: Reset and INIT (code 9) set top to 0, tag every entry empty and clear all flags and C1.
- R11: Stack-fault and invalid-operation flags stay set until CLEX (code 10) or INIT; CLEX leaves top, tags and C1 alone.
- R12: READ (code 6) returns ST(i) on rd_data with rd_valid high in the cycle after the request; reading an empty entry is an underflow. WRITE (code 5) stores wr_data in ST(i), tags it occupied and never faults. rd_valid is high only after a successful POP or READ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Request strobe |
| op_code | input | 4 | Request code (see requirements; unused codes do nothing) |
| op_idx | input | 3 | Logical stack index i |
| wr_data | input | 80 | Word for PUSH and WRITE |
| rd_data | output | 80 | Word returned by POP or READ |
| rd_valid | output | 1 | rd_data is new this cycle |
| status | output | 16 | Status word |

## Verification
The assertions assume that op_code and op_idx are stable and known whenever op_valid is high. They also assume that a request issued while the stack is full or empty is still a legal request whose only effect is the fault. The stimulus drives every input on the falling clock edge, so each request is settled long before the sampling edge. The random mix keeps INIT rare and CLEX occasional, so that long runs of full-stack overflow and empty-stack underflow are reached as well as the wrap of the top pointer through 7 and 0.

// File: rtl/fstack_regfile.sv
module fstack_regfile #(
  parameter int W = 80
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic [3:0]   op_code,
  input  logic [2:0]   op_idx,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  output logic         rd_valid,
  output logic [15:0]  status
);
  localparam logic [3:0] OP_PUSH = 4'd1, OP_DUP = 4'd2, OP_POP = 4'd3, OP_STPOP = 4'd4,
                         OP_WRITE = 4'd5, OP_READ = 4'd6, OP_XCHG = 4'd7, OP_XCHG1 = 4'd8,
                         OP_INIT = 4'd9, OP_CLEX = 4'd10;

  logic [W-1:0] ent_q [8];
  logic [7:0]   tag_q;
  logic [2:0]   top_q;
  logic         sf_q, ie_q, c1_q;
  logic [W-1:0] rd_q;
  logic         rdv_q;

  logic [2:0] sel_idx, ph_i, ph_n, ph_p;
  logic       under, over, fault;

  assign sel_idx = (op_code == OP_XCHG1) ? 3'd1 : op_idx;
  assign ph_i    = top_q + sel_idx;
  assign ph_n    = top_q - 3'd1;
  assign ph_p    = top_q + 3'd1;

  always_comb begin
    under = 1'b0;
    over  = 1'b0;
    if (op_valid) begin
      case (op_code)
        OP_PUSH:  over  = tag_q[ph_n];
        OP_DUP: begin
          under = !tag_q[ph_i];
          over  = tag_q[ph_i] && tag_q[ph_n];
        end
        OP_POP, OP_STPOP: under = !tag_q[top_q];
        OP_READ:  under = !tag_q[ph_i];
        OP_XCHG, OP_XCHG1: under = !tag_q[top_q] || !tag_q[ph_i];
        default: ;
      endcase
    end
  end
  assign fault = under || over;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      top_q <= '0;
      tag_q <= '0;
      sf_q  <= 1'b0;
      ie_q  <= 1'b0;
      c1_q  <= 1'b0;
      rdv_q <= 1'b0;
    end else begin
      rdv_q <= 1'b0;
      if (fault) begin
        sf_q <= 1'b1;
        ie_q <= 1'b1;
        c1_q <= over;
      end else if (op_valid) begin
        case (op_code)
          OP_PUSH, OP_DUP: begin
            tag_q[ph_n] <= 1'b1;
            top_q       <= ph_n;
          end
          OP_POP: begin
            tag_q[top_q] <= 1'b0;
            top_q        <= ph_p;
            rdv_q        <= 1'b1;
          end
          OP_STPOP: begin
            tag_q[ph_i]  <= 1'b1;
            tag_q[top_q] <= 1'b0;
            top_q        <= ph_p;
          end
          OP_WRITE: tag_q[ph_i] <= 1'b1;
          OP_READ:  rdv_q <= 1'b1;
          OP_XCHG, OP_XCHG1: c1_q <= 1'b0;
          OP_INIT: begin
            top_q <= '0;
            tag_q <= '0;
            sf_q  <= 1'b0;
            ie_q  <= 1'b0;
            c1_q  <= 1'b0;
          end
          OP_CLEX: begin
            sf_q <= 1'b0;
            ie_q <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (op_valid && !fault) begin
      case (op_code)
        OP_PUSH:  ent_q[ph_n] <= wr_data;
        OP_DUP:   ent_q[ph_n] <= ent_q[ph_i];
        OP_POP:   rd_q <= ent_q[top_q];
        OP_STPOP: ent_q[ph_i] <= ent_q[top_q];
        OP_WRITE: ent_q[ph_i] <= wr_data;
        OP_READ:  rd_q <= ent_q[ph_i];
        OP_XCHG, OP_XCHG1: begin
          ent_q[top_q] <= ent_q[ph_i];
          ent_q[ph_i]  <= ent_q[top_q];
        end
        default: ;
      endcase
    end
  end

  assign rd_data  = rd_q;
  assign rd_valid = rdv_q;
  assign status   = {2'b00, top_q, 1'b0, c1_q, 1'b0, ie_q, sf_q, 5'b00000, ie_q};
endmodule

// File: rtl/fstack_regfile_chk.sv
module fstack_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic [3:0]  op_code,
  input logic [15:0] status,
  input logic [7:0]  tag
);
  logic [2:0] top, tgt;
  assign top = status[13:11];
  assign tgt = top - 3'd1;

  AST_PUSH_MOVES_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == 4'd1 && !tag[tgt] |=> top == $past(top) - 3'd1); // R2
  AST_POP_MOVES_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == 4'd3 && tag[top] |=> top == $past(top) + 3'd1 && !tag[$past(top)]); // R4
  AST_NO_OVERFLOW_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == 4'd1 && tag[tgt] |=> $stable(top) && $stable(tag) && status[9] && status[6]); // R8
  AST_FAULT_IS_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    status[6] |-> status[0]); // R7
  AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == 4'd9 |=> status == 16'h0 && tag == 8'h0); // R10
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] && !(op_valid && (op_code == 4'd9 || op_code == 4'd10)) |=> status[0]); // R11
endmodule

bind fstack_regfile fstack_regfile_chk chk_i (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .status(status), .tag(tag_q)
);

// File: tb/fstack_regfile_tb.sv
module fstack_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = '0;
  logic [2:0]  op_idx = '0;
  logic [79:0] wr_data = '0;
  logic [79:0] rd_data;
  logic        rd_valid;
  logic [15:0] status;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [79:0] m_ent [8];
  logic [7:0]  m_tag;
  logic [2:0]  m_top;
  logic        m_sf, m_ie, m_c1, m_rdv;
  logic [79:0] m_rd;

  always #10 clk = ~clk;

  fstack_regfile dut_i (.clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_idx(op_idx), .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid), .status(status));

  function automatic logic [15:0] exp_status();
    return {2'b00, m_top, 1'b0, m_c1, 1'b0, m_ie, m_sf, 5'b0, m_ie};
  endfunction

  task automatic chk(string tag, logic [79:0] act, logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic m_reset();
    m_tag = '0; m_top = '0; m_sf = 0; m_ie = 0; m_c1 = 0; m_rdv = 0;
  endtask

  task automatic m_fault(logic ovf);
    m_sf = 1; m_ie = 1; m_c1 = ovf;
  endtask

  function automatic string op_tag(logic [3:0] op);
    case (op)
      4'd1: return "R2";  4'd2: return "R3";  4'd3: return "R4";  4'd4: return "R5";
      4'd5: return "R1";  4'd6: return "R12"; 4'd7, 4'd8: return "R6";
      4'd9: return "R10"; 4'd10: return "R11";
      default: return "R9";
    endcase
  endfunction

  task automatic m_apply(logic [3:0] op, logic [2:0] idx, logic [79:0] d, output logic flt);
    logic [2:0] t, pi, pn;
    logic [79:0] tmp;
    t = m_top; pi = t + ((op == 4'd8) ? 3'd1 : idx); pn = t - 3'd1;
    m_rdv = 0; flt = 0;
    case (op)
      4'd1: if (m_tag[pn]) begin m_fault(1); flt = 1; end
            else begin m_ent[pn] = d; m_tag[pn] = 1; m_top = pn; end
      4'd2: if (!m_tag[pi]) begin m_fault(0); flt = 1; end
            else if (m_tag[pn]) begin m_fault(1); flt = 1; end
            else begin m_ent[pn] = m_ent[pi]; m_tag[pn] = 1; m_top = pn; end
      4'd3: if (!m_tag[t]) begin m_fault(0); flt = 1; end
            else begin m_rd = m_ent[t]; m_rdv = 1; m_tag[t] = 0; m_top = t + 3'd1; end
      4'd4: if (!m_tag[t]) begin m_fault(0); flt = 1; end
            else begin m_ent[pi] = m_ent[t]; m_tag[pi] = 1; m_tag[t] = 0; m_top = t + 3'd1; end
      4'd5: begin m_ent[pi] = d; m_tag[pi] = 1; end
      4'd6: if (!m_tag[pi]) begin m_fault(0); flt = 1; end
            else begin m_rd = m_ent[pi]; m_rdv = 1; end
      4'd7, 4'd8: if (!m_tag[t] || !m_tag[pi]) begin m_fault(0); flt = 1; end
            else begin tmp = m_ent[t]; m_ent[t] = m_ent[pi]; m_ent[pi] = tmp; m_c1 = 0; end
      4'd9: m_reset();
      4'd10: begin m_sf = 0; m_ie = 0; end
      default: ;
    endcase
  endtask

  task automatic do_op(logic [3:0] op, logic [2:0] idx, logic [79:0] d);
    logic flt;
    string tg;
    op_valid = 1; op_code = op; op_idx = idx; wr_data = d;
    m_apply(op, idx, d, flt);
    tg = flt ? "R7" : op_tag(op);
    @(negedge clk);
    op_valid = 0;
    chk({tg, " status"}, 80'(status), 80'(exp_status()));
    chk({tg, " rd_valid"}, 80'(rd_valid), 80'(m_rdv));
    if (m_rdv) chk({tg, " rd_data"}, rd_data, m_rd);
  endtask

  function automatic logic [79:0] rnd80();
    logic [31:0] a, b, c;
    a = $urandom; b = $urandom; c = $urandom;
    return {a[15:0], b, c};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [2:0] top0;
    void'($urandom(32'd4242));
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 reset status", 80'(status), 80'h0);
    chk("R10 reset rd_valid", 80'(rd_valid), 80'h0);

    for (int k = 0; k < 8; k++) do_op(4'd1, 3'd0, 80'(k + 1));
    chk("R2 top after 8 pushes", 80'(status[13:11]), 80'd0);
    do_op(4'd6, 3'd7, '0);
    chk("R1 ST7 after 8 pushes", rd_data, 80'd1);
    top0 = status[13:11];
    do_op(4'd1, 3'd0, 80'hBAD);
    chk("R7 overflow C1", 80'(status[9]), 80'd1);
    chk("R8 top unchanged on overflow", 80'(status[13:11]), 80'(top0));
    do_op(4'd6, 3'd0, '0);
    chk("R8 top entry unchanged on overflow", rd_data, 80'd8);
    chk("R9 summary bit follows bit 0", 80'(status[7]), 80'(status[0]));
    do_op(4'd10, 3'd0, '0);
    chk("R11 flags cleared by clear command", 80'(status[7:0]), 80'h0);
    do_op(4'd8, 3'd0, '0);
    do_op(4'd6, 3'd0, '0);
    chk("R6 implicit ST1 swap", rd_data, 80'd7);
    do_op(4'd4, 3'd2, '0);
    for (int k = 0; k < 7; k++) do_op(4'd3, 3'd0, '0);
    do_op(4'd3, 3'd0, '0);
    chk("R7 underflow C1", 80'(status[9]), 80'd0);
    chk("R7 underflow fault", 80'(status[6]), 80'd1);
    do_op(4'd1, 3'd0, 80'h1234);
    chk("R11 flags sticky after good push", 80'(status[6]), 80'd1);
    do_op(4'd2, 3'd0, '0);
    do_op(4'd3, 3'd0, '0);
    chk("R3 dup of ST0", rd_data, 80'h1234);
    do_op(4'd4, 3'd0, '0);
    chk("R5 store-pop index 0 empties", 80'(status[13:11]), 80'd0);
    do_op(4'd9, 3'd0, '0);
    chk("R10 init status", 80'(status), 80'h0);

    for (int n = 0; n < 6000; n++) begin
      logic [31:0] r;
      logic [3:0] op;
      r = $urandom % 100;
      if (r < 1) op = 4'd9;
      else if (r < 4) op = 4'd10;
      else if (r < 6) op = 4'd0;
      else if (r < 24) op = 4'd1;
      else if (r < 32) op = 4'd2;
      else if (r < 48) op = 4'd3;
      else op = 4'(4 + ($urandom % 5));
      do_op(op, 3'($urandom), rnd80());
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule